// File: doc/BRIEF.md
# Variable Frequency Tick Generator

This block is a numerically controlled oscillator. A 16-bit phase register advances by an increment on every reference clock while the run input is high. The top bit of that register is a square wave whose frequency is the increment times 2^-16 times the reference clock rate. A companion one-cycle enable pulse marks each rising edge of the square wave, so a downstream counter can step at the synthesized rate without a second clock domain.

The control word reaches the block as two 8-bit halves, each with its own write strobe. A new word goes into use only when both halves have arrived, in either order or in the same cycle. The increment is derived from the control word by folding. Words below 0x8000 are used as they are. Words at or above 0x8000 are replaced by their 16-bit two's complement, so 0x8000 gives an increment of 32768 and 0xC000 gives an increment of 0x4000.

Top module: `nco_gen`

## Requirements
- R1: After reset the active control word is zero and both outputs are low. While running with no word committed, no pulse and no square-wave high level appear.
- R2: A control word takes effect on the clock edge at which its second half is written: high then low, low then high, or both strobes in one cycle. When a half is written twice, its latest value is used.
- R3: Writing only one half leaves the output behaviour unchanged until the other half is written.
- R4: A control word whose bit 15 is set acts as its 16-bit two's complement. For example, 0xFC00 behaves exactly like 0x0400.
- R5: While running, the phase register adds the increment on every clock edge, wrapping modulo 2^16. The square-wave output is its bit 15. For a power-of-two word the wave has exactly 50% duty over whole periods.
- R6: The pulse output is high for one clock in the same cycle that the square wave rises, and at no other time.
- R7: While the run input is low, both outputs are low and the phase register is held at zero. After run returns high with increment W, the first pulse comes on edge ceil(32768/W).
- R8: The word 0x8000 gives an increment of 32768. The wave then toggles every clock and a pulse occurs every second clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Run enable; low holds the phase at zero |
| hi_byte | input | 8 | Upper half of the control word |
| hi_wr | input | 1 | Write strobe for the upper half |
| lo_byte | input | 8 | Lower half of the control word |
| lo_wr | input | 1 | Write strobe for the lower half |
| wave_out | output | 1 | Square wave at the synthesized frequency |
| tick_out | output | 1 | One-cycle enable at each rising edge of wave_out |

## Verification
The hardest case to reach from the ports is a half-written word sitting in staging while the oscillator keeps running on the old word. The stimulus leaves a single half pending for many cycles, and sometimes rewrites that same half before completing the pair. This shows that staging never leaks into the increment, and that the completed word uses the latest value of each half. Folding is exercised with words above 0x8000 that have a known unfolded twin. The result is compared through pulse counts and duty counts over whole periods.

// File: rtl/nco_gen.sv
module nco_gen #(
  parameter int ACC_W  = 16,
  parameter int HALF_W = ACC_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] hi_byte,
  input  logic              hi_wr,
  input  logic [HALF_W-1:0] lo_byte,
  input  logic              lo_wr,
  output logic              wave_out,
  output logic              tick_out
);
  localparam int MSB = ACC_W - 1;

  logic [HALF_W-1:0] hi_stage, lo_stage, hi_next, lo_next;
  logic              hi_pend, lo_pend, hi_have, lo_have;
  logic [ACC_W-1:0]  active_cw, inc, acc, acc_nxt;
  logic              tick_q;

  assign hi_next = hi_wr ? hi_byte : hi_stage;
  assign lo_next = lo_wr ? lo_byte : lo_stage;
  assign hi_have = hi_pend | hi_wr;
  assign lo_have = lo_pend | lo_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_stage  <= '0;
      lo_stage  <= '0;
      hi_pend   <= 1'b0;
      lo_pend   <= 1'b0;
      active_cw <= '0;
    end else begin
      hi_stage <= hi_next;
      lo_stage <= lo_next;
      if (hi_have && lo_have) begin
        active_cw <= {hi_next, lo_next};
        hi_pend   <= 1'b0;
        lo_pend   <= 1'b0;
      end else begin
        hi_pend <= hi_have;
        lo_pend <= lo_have;
      end
    end
  end

  assign inc     = active_cw[MSB] ? (~active_cw + 1'b1) : active_cw;
  assign acc_nxt = acc + inc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      acc    <= '0;
      tick_q <= 1'b0;
    end else begin
      acc    <= acc_nxt;
      tick_q <= ~acc[MSB] & acc_nxt[MSB];
    end
  end

  assign wave_out = run & acc[MSB];
  assign tick_out = run & tick_q;
endmodule

// File: rtl/nco_gen_chk.sv
module nco_gen_chk #(
  parameter int ACC_W  = 16,
  parameter int HALF_W = ACC_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [HALF_W-1:0] hi_byte,
  input logic              hi_wr,
  input logic [HALF_W-1:0] lo_byte,
  input logic              lo_wr,
  input logic              lo_pend,
  input logic              hi_pend,
  input logic [ACC_W-1:0]  active_cw,
  input logic [ACC_W-1:0]  inc,
  input logic [ACC_W-1:0]  acc,
  input logic              wave_out,
  input logic              tick_out
);
  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> (wave_out && !$past(wave_out))); // R6
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> !tick_out); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (acc == '0)); // R7
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !lo_wr && !lo_pend) |=> $stable(active_cw)); // R3
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !hi_wr && !hi_pend) |=> $stable(active_cw)); // R3
  AST_PAIR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && lo_wr) |=> (active_cw == {$past(hi_byte), $past(lo_byte)})); // R2
  AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc <= (ACC_W'(1) << (ACC_W - 1))) && ((active_cw != '0) == (inc != '0))); // R4
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(rst_n)) |-> (acc == ACC_W'($past(acc) + $past(inc)))); // R5
endmodule

bind nco_gen nco_gen_chk #(.ACC_W(ACC_W), .HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .hi_byte(hi_byte), .hi_wr(hi_wr),
  .lo_byte(lo_byte), .lo_wr(lo_wr), .lo_pend(lo_pend), .hi_pend(hi_pend),
  .active_cw(active_cw), .inc(inc), .acc(acc),
  .wave_out(wave_out), .tick_out(tick_out)
);

// File: tb/nco_gen_test.sv
module nco_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [7:0] hi_byte = '0, lo_byte = '0;
  logic hi_wr = 1'b0, lo_wr = 1'b0;
  logic wave_out, tick_out;

  int errors = 0, checks = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  int m_acc = 0, m_word = 0, m_hs = 0, m_ls = 0;
  bit m_hp = 0, m_lp = 0, m_tick = 0;

  nco_gen uut (.clk(clk), .rst_n(rst_n), .run(run), .hi_byte(hi_byte), .hi_wr(hi_wr),
               .lo_byte(lo_byte), .lo_wr(lo_wr), .wave_out(wave_out), .tick_out(tick_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_word = 0; m_hs = 0; m_ls = 0; m_hp = 0; m_lp = 0; m_tick = 0;
    end else begin
      int w, old;
      bit hv, lv;
      w   = (m_word >= 32768) ? 65536 - m_word : m_word;
      old = m_acc;
      if (run) begin
        m_acc  = (m_acc + w) % 65536;
        m_tick = (old < 32768) && (m_acc >= 32768);
      end else begin
        m_acc = 0; m_tick = 0;
      end
      if (hi_wr) m_hs = int'(hi_byte);
      if (lo_wr) m_ls = int'(lo_byte);
      hv = m_hp || hi_wr;
      lv = m_lp || lo_wr;
      if (hv && lv) begin
        m_word = m_hs * 256 + m_ls; m_hp = 0; m_lp = 0;
      end else begin
        m_hp = hv; m_lp = lv;
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, int'(wave_out), int'(run && m_acc >= 32768), "wave_out vs model");
      check(cur_req, int'(tick_out), int'(run && m_tick), "tick_out vs model");
    end
  end

  task automatic wr(bit h, bit l, logic [7:0] hb, logic [7:0] lb);
    hi_wr = h; lo_wr = l; hi_byte = hb; lo_byte = lb;
    @(negedge clk);
    hi_wr = 0; lo_wr = 0;
  endtask

  task automatic measure(int n, output int highs, output int ticks);
    highs = 0; ticks = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      highs += int'(wave_out);
      ticks += int'(tick_out);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int h, t;
    repeat (3) @(negedge clk);
    check("R1", int'(wave_out), 0, "wave in reset");
    check("R1", int'(tick_out), 0, "tick in reset");
    rst_n = 1; run = 1;
    cur_req = "R1";
    measure(50, h, t);
    check("R1", h + t, 0, "activity with no word");

    cur_req = "R3";
    wr(1, 0, 8'h04, 8'h00);
    measure(100, h, t);
    check("R3", h + t, 0, "activity after upper half only");
    wr(1, 0, 8'h08, 8'h00);
    measure(20, h, t);
    check("R3", h + t, 0, "activity after rewriting upper half");

    cur_req = "R2";
    lo_byte = 8'h00; lo_wr = 1;
    @(negedge clk); lo_wr = 0;
    measure(512, h, t);
    check("R2", t, 16, "ticks for 0x0800 (latest half)");
    check("R5", h, 256, "duty highs for 0x0800");

    cur_req = "R4";
    wr(0, 1, 8'h00, 8'h00);
    measure(30, h, t);
    wr(1, 0, 8'hFC, 8'h00);
    measure(640, h, t);
    check("R4", t, 10, "ticks for folded 0xFC00");
    check("R4", h, 320, "highs for folded 0xFC00");

    cur_req = "R8";
    wr(1, 1, 8'h80, 8'h00);
    measure(100, h, t);
    check("R8", t, 50, "ticks for 0x8000");
    check("R8", h, 50, "highs for 0x8000");

    cur_req = "R7";
    wr(1, 1, 8'h04, 8'h00);
    run = 0;
    measure(20, h, t);
    check("R7", h + t, 0, "activity while stopped");
    run = 1;
    begin
      int first = 0;
      for (int i = 1; i <= 40 && first == 0; i++) begin
        @(negedge clk);
        if (tick_out) first = i;
      end
      check("R7", first, 32, "edge of first tick after restart");
    end

    cur_req = "R5";
    wr(1, 1, 8'h12, 8'h34);
    measure(300, h, t);
    cur_req = "R4";
    wr(1, 1, 8'h9A, 8'hBC);
    measure(300, h, t);
    cur_req = "R6";
    wr(1, 1, 8'h7F, 8'hFF);
    measure(200, h, t);
    check("R6", t, 100, "ticks for 0x7FFF");

    finish_run();
  end
endmodule